// File: doc/BRIEF.md
# I2C Stuck-Bus Flush Sequencer

This block drives a recovery burst onto one downstream I2C channel whose data line is held low by a hung device. When an upstream detector raises a one-cycle trigger, and the automatic-flush enable is set, the block takes over the channel's clock and data lines. It clocks out a programmable byte on SDA, most significant bit first, and adds one extra clock with SDA released as a NACK. It sends this nine-clock group twice and then closes the bus with a STOP condition. A device that was stuck in the middle of a transfer sees enough clocks to finish its byte, sees a NACK and then sees a STOP, so it returns to idle.

Both line outputs are open-drain requests: a 1 releases the line and a 0 pulls it low. The SCL half-period is a whole number of system clocks set by a parameter. The byte that drives SDA is held in a small writable register that resets to all ones. The block copies that register when it accepts a trigger, so a write made during a burst only affects the next burst. A busy output covers the whole burst, and a one-cycle done pulse marks its end.

Top module: `i2c_flush_gen`

## Requirements
- R1: After a synchronous reset, and at any time while not busy, scl_out and sda_out are 1 (released), busy is 0 and done is 0. Reset also aborts a burst in progress.
- R2: A trigger is accepted on a clock edge only when auto_flush_en is 1 and busy is 0. busy is 1 from the next cycle onward. When auto_flush_en is 0 a trigger has no effect.
- R3: Every SCL low phase and every SCL high phase lasts exactly HALF_DIV clock cycles. A burst has 2*(PAT_W+1) full SCL pulses, each low then high, followed by one more SCL rise that belongs to the STOP.
- R4: In each of the two groups, the SDA values for clocks 1 to PAT_W are the pattern bits, most significant bit first. Clock PAT_W+1 is a NACK with SDA released (1).
- R5: SDA changes only while SCL is low. It takes its new value one cycle after SCL falls. The single exception is the STOP rising edge of SDA.
- R6: After the last NACK high phase, the STOP runs as follows. SCL is low while SDA goes low, one half-period. SCL is then released while SDA stays low, one half-period. SDA is then released while SCL stays high, one half-period.
- R7: busy stays high for exactly (4*(PAT_W+1)+3)*HALF_DIV cycles. done is a single-cycle pulse in the first cycle after busy falls.
- R8: A trigger that arrives while busy is 1 is ignored. The running burst continues unchanged and no second burst follows.
- R9: The byte sent is the value of the pattern register at the edge where the trigger is accepted. A write on that same edge, or any later write during the burst, only applies to later bursts.
- R10: A pattern write (pat_wr_en = 1) loads pat_wr_data at the clock edge. The register resets to all ones, so a burst with no prior write sends 1s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_flush_en | input | 1 | Configuration enable; triggers are ignored when 0 |
| trigger | input | 1 | Start request from the lock-up detector |
| pat_wr_en | input | 1 | Write strobe for the pattern register |
| pat_wr_data | input | PAT_W | Pattern value to store |
| scl_out | output | 1 | SCL drive request, 1 = release, 0 = pull low |
| sda_out | output | 1 | SDA drive request, 1 = release, 0 = pull low |
| busy | output | 1 | High for the whole burst, STOP included |
| done | output | 1 | One-cycle pulse after the STOP completes |

## Verification
The bench builds the block with HALF_DIV = 3, PAT_W = 8 and REPEATS = 2. Three is the smallest half-period at which the one-cycle SDA lag inside a low phase can be seen apart from the phase edges, and it keeps a full burst to 117 cycles. That leaves room for several patterns, a held trigger, a write on the trigger edge and a reset in mid-burst. With the default byte width and group count, the bench observes the exact 18-pulse burst and the STOP tail.

// File: rtl/flush_pkg.sv
// Shared types for the stuck-bus flush sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package flush_pkg;

    // Phase of the burst; the two STOP phases after STOP_A follow a released SCL.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } flush_state_e;

endpackage

// File: rtl/flush_tick.sv
// Half-period timer: while run is high it emits one tick every HALF_DIV cycles.
// The first tick comes HALF_DIV cycles after run rises.
// Assumes: HALF_DIV >= 2, and run is the sequencer's busy output.
module flush_tick #(
    parameter int HALF_DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_LAST);

    // Count cycles within the current half-period; hold at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

endmodule

// File: rtl/flush_pattern.sv
// Writable pattern register holding the SDA byte for the next burst.
// Assumes: a write is a single-cycle strobe; the reset value is a parameter.
module flush_pattern #(
    parameter int              PAT_W     = 8,
    parameter logic [PAT_W-1:0] PAT_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PAT_W-1:0] wr_data,
    output logic [PAT_W-1:0] pattern
);
    // Store the pattern; reset restores the default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern <= PAT_RESET;
        end else if (wr_en) begin
            pattern <= wr_data;
        end
    end

    AST_PAT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pattern == $past(wr_data))); // R10

endmodule

// File: rtl/flush_seq.sv
// Burst sequencer: it sends REPEATS groups of PAT_W data clocks plus one NACK
// clock, then a STOP, and drives registered open-drain line requests.
// Assumes: tick comes from flush_tick running on this module's busy output.
// start is already qualified by the enable and is ignored while busy.
module flush_seq #(
    parameter int PAT_W   = 8,
    parameter int REPEATS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic [PAT_W-1:0] pattern,
    output logic             scl_out,
    output logic             sda_out,
    output logic             busy,
    output logic             done
);
    import flush_pkg::*;

    localparam int POS_W = $clog2(PAT_W + 1);
    localparam int GRP_W = (REPEATS > 1) ? $clog2(REPEATS) : 1;
    localparam logic [POS_W-1:0] POS_NACK = POS_W'(PAT_W);
    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(REPEATS - 1);

    flush_state_e     st_q, st_n;
    logic [POS_W-1:0] pos_q, pos_n;
    logic [GRP_W-1:0] grp_q, grp_n;
    logic [PAT_W-1:0] snap_q, snap_n;
    logic [PAT_W-1:0] sh_q, sh_n;
    logic             scl_q, scl_n;
    logic             sda_q, sda_n;
    logic             done_q, done_n;

    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign scl_out = scl_q;
    assign sda_out = sda_q;

    // Next-state logic: advance one phase per tick, and copy the pattern on start.
    always_comb begin
        st_n   = st_q;
        pos_n  = pos_q;
        grp_n  = grp_q;
        snap_n = snap_q;
        sh_n   = sh_q;
        done_n = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_n   = ST_LOW;
                    pos_n  = '0;
                    grp_n  = '0;
                    snap_n = pattern;
                    sh_n   = pattern;
                end
            end
            ST_LOW: begin
                if (tick) st_n = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick) begin
                    if (pos_q == POS_NACK) begin
                        if (grp_q == GRP_LAST) begin
                            st_n = ST_STOP_A;
                        end else begin
                            st_n  = ST_LOW;
                            grp_n = grp_q + 1'b1;
                            pos_n = '0;
                            sh_n  = snap_q;
                        end
                    end else begin
                        st_n  = ST_LOW;
                        pos_n = pos_q + 1'b1;
                        sh_n  = {sh_q[PAT_W-2:0], 1'b0};
                    end
                end
            end
            ST_STOP_A: begin
                if (tick) st_n = ST_STOP_B;
            end
            ST_STOP_B: begin
                if (tick) st_n = ST_STOP_C;
            end
            ST_STOP_C: begin
                if (tick) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Line decode from the next phase: SCL low in data-low and STOP_A phases.
    always_comb begin
        scl_n = !((st_n == ST_LOW) || (st_n == ST_STOP_A));
        unique case (st_n)
            ST_LOW, ST_HIGH: sda_n = (pos_n == POS_NACK) ? 1'b1 : sh_n[PAT_W-1];
            ST_STOP_A,
            ST_STOP_B:       sda_n = 1'b0;
            default:         sda_n = 1'b1;
        endcase
    end

    // State and line registers. SDA only moves once SCL is already low, or for the STOP rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pos_q  <= '0;
            grp_q  <= '0;
            snap_q <= '1;
            sh_q   <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            pos_q  <= pos_n;
            grp_q  <= grp_n;
            snap_q <= snap_n;
            sh_q   <= sh_n;
            scl_q  <= scl_n;
            done_q <= done_n;
            if (!scl_q || (st_n == ST_STOP_C)) begin
                sda_q <= sda_n;
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl_out && sda_out)); // R1

    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(tick)) |-> $stable(st_q)); // R3

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_NACK); // R4

    AST_SDA_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_out && $past(scl_out) && !$stable(sda_out)) |-> (sda_out && st_q == ST_STOP_C)); // R5

    AST_STOP_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP_A && $past(st_q) == ST_HIGH) |-> ($past(pos_q) == POS_NACK)); // R6

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(snap_q)); // R9

endmodule

// File: rtl/i2c_flush_gen.sv
// Top of the stuck-bus flush sequencer. It qualifies the trigger with the
// auto-flush enable and wires the pattern register, the half-period timer and
// the burst sequencer together.
// Assumes: HALF_DIV >= 2, PAT_W >= 2, REPEATS >= 1; the outputs feed open-drain pads.
module i2c_flush_gen #(
    parameter int               HALF_DIV  = 250,
    parameter int               PAT_W     = 8,
    parameter int               REPEATS   = 2,
    parameter logic [PAT_W-1:0] PAT_RESET = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_flush_en,
    input  logic             trigger,
    input  logic             pat_wr_en,
    input  logic [PAT_W-1:0] pat_wr_data,
    output logic             scl_out,
    output logic             sda_out,
    output logic             busy,
    output logic             done
);
    logic             start_req;
    logic             half_tick;
    logic [PAT_W-1:0] cur_pattern;

    assign start_req = trigger && auto_flush_en;

    flush_pattern #(
        .PAT_W     (PAT_W),
        .PAT_RESET (PAT_RESET)
    ) u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pat_wr_en),
        .wr_data (pat_wr_data),
        .pattern (cur_pattern)
    );

    flush_tick #(
        .HALF_DIV (HALF_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (half_tick)
    );

    flush_seq #(
        .PAT_W   (PAT_W),
        .REPEATS (REPEATS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_req),
        .tick    (half_tick),
        .pattern (cur_pattern),
        .scl_out (scl_out),
        .sda_out (sda_out),
        .busy    (busy),
        .done    (done)
    );

    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !auto_flush_en) |=> !busy); // R2

    AST_BUSY_IGNORES_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trigger) |=> !done || !busy); // R8

endmodule

// File: tb/i2c_flush_gen_test.sv
// Bench: a behavioural queue model of the expected line waveform, compared on every clock.
module i2c_flush_gen_test;
    localparam int H        = 3;
    localparam int PW       = 8;
    localparam int REP      = 2;
    localparam int BUSY_LEN = (2 * (PW + 1) * REP + 3) * H;
    localparam int NRISE    = (PW + 1) * REP + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          auto_en = 1'b0;
    logic          trig = 1'b0;
    logic          wr = 1'b0;
    logic [PW-1:0] wdata = '0;
    logic          scl, sda, busy, done;

    always #5 clk = ~clk;

    i2c_flush_gen #(.HALF_DIV(H), .PAT_W(PW), .REPEATS(REP)) uut (
        .clk(clk), .rst_n(rst_n), .auto_flush_en(auto_en), .trigger(trig),
        .pat_wr_en(wr), .pat_wr_data(wdata),
        .scl_out(scl), .sda_out(sda), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Reference model: each queue entry is {busy, done, scl, sda} for one cycle.
    logic [3:0]    q[$];
    logic [3:0]    exp_v = 4'b0011;
    logic [PW-1:0] pat_m = '1;
    logic [PW-1:0] mon_pat = '1;
    bit            live = 0;

    task automatic push(input logic [3:0] v, input int n);
        for (int i = 0; i < n; i++) q.push_back(v);
    endtask

    task automatic build(input logic [PW-1:0] p);
        logic prev;
        logic b;
        prev = 1'b1;
        for (int g = 0; g < REP; g++) begin
            for (int k = 0; k <= PW; k++) begin
                b = (k == PW) ? 1'b1 : p[PW-1-k];
                push({3'b100, prev}, 1);
                push({3'b100, b}, H - 1);
                push({3'b101, b}, H);
                prev = b;
            end
        end
        push({3'b100, prev}, 1);
        push(4'b1000, H - 1);
        push(4'b1010, H);
        push(4'b1011, H);
        push(4'b0111, 1);
    endtask

    always @(posedge clk) begin
        live = 1;
        if (!rst_n) begin
            q.delete();
            exp_v = 4'b0011;
            pat_m = '1;
        end else begin
            if (q.size() == 0 && trig && auto_en) begin
                build(pat_m);
                mon_pat = pat_m;
            end
            if (q.size() > 0) exp_v = q.pop_front();
            else              exp_v = 4'b0011;
            if (wr) pat_m = wdata;
        end
    end

    // Per-cycle comparison plus per-burst monitors.
    int             blen = 0;
    int             rises = 0;
    int             stop_rises = 0;
    logic [NRISE-1:0] bits = '0;
    logic           prev_scl = 1'b1;
    logic           prev_sda = 1'b1;
    logic           prev_busy = 1'b0;
    bit             wd_hit = 0;

    always @(negedge clk) begin
        if (live && !wd_hit) begin
            chk(busy == exp_v[3], "R2 R8 busy", busy, exp_v[3]);
            chk(done == exp_v[2], "R7 done", done, exp_v[2]);
            chk(scl  == exp_v[1], "R3 R6 scl", scl, exp_v[1]);
            chk(sda  == exp_v[0], "R4 R5 sda", sda, exp_v[0]);
            if (!rst_n) begin
                blen = 0; rises = 0; stop_rises = 0; bits = '0;
            end else begin
                if (busy) begin
                    blen++;
                    if (scl && !prev_scl) begin
                        rises++;
                        bits = {bits[NRISE-2:0], sda};
                    end
                    if (scl && prev_scl && sda != prev_sda) begin
                        stop_rises++;
                        chk(sda == 1'b1 && rises == NRISE, "R5 sda moved under high scl", {sda, 8'(rises)}, {1'b1, 8'(NRISE)});
                    end
                end
                if (!busy && prev_busy) begin
                    chk(blen == BUSY_LEN, "R7 busy length", blen, BUSY_LEN);
                    chk(rises == NRISE, "R3 scl rise count", rises, NRISE);
                    chk(stop_rises == 1, "R6 stop sda release", stop_rises, 1);
                    chk(bits == {mon_pat, 1'b1, mon_pat, 1'b1, 1'b0}, "R4 R9 R10 sampled bits",
                        bits, {mon_pat, 1'b1, mon_pat, 1'b1, 1'b0});
                    blen = 0; rises = 0; stop_rises = 0; bits = '0;
                end
            end
        end
        prev_scl  = scl;
        prev_sda  = sda;
        prev_busy = busy;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !wd_hit) begin
            wd_hit = 1;
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic write_pat(input logic [PW-1:0] v);
        @(negedge clk) begin wr = 1'b1; wdata = v; end
        @(negedge clk) wr = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(!busy && !done && scl && sda, "R1 reset state", {busy, done, scl, sda}, 4'b0011);

        // R2: trigger with the enable clear has no effect
        pulse_trig();
        repeat (10) @(negedge clk);
        chk(!busy && scl && sda, "R2 disabled trigger ignored", {busy, scl, sda}, 3'b011);

        // R10: first burst uses the reset pattern of all ones
        auto_en = 1'b1;
        pulse_trig();
        wait_idle();

        // R8, R9: second trigger and a write during a burst do not disturb it
        write_pat(8'hA5);
        pulse_trig();
        repeat (20) @(negedge clk);
        pulse_trig();
        write_pat(8'h3C);
        wait_idle();
        repeat (5) @(negedge clk);
        chk(!busy, "R8 no second burst", busy, 1'b0);
        pulse_trig();
        wait_idle();

        // R4: several patterns including the edge bits
        write_pat(8'h00); pulse_trig(); wait_idle();
        write_pat(8'h80); pulse_trig(); wait_idle();
        write_pat(8'h01); pulse_trig(); wait_idle();
        write_pat(8'h5A); pulse_trig(); wait_idle();

        // R9: write on the accepting edge does not affect this burst
        @(negedge clk) begin wr = 1'b1; wdata = 8'hC3; trig = 1'b1; end
        @(negedge clk) begin wr = 1'b0; trig = 1'b0; end
        wait_idle();

        // R2 R7: a held trigger restarts right after the done cycle
        @(negedge clk) trig = 1'b1;
        repeat (2 * BUSY_LEN + 10) @(negedge clk);
        trig = 1'b0;
        wait_idle();

        // R1 R10: reset in mid-burst aborts it and restores the all-ones pattern
        pulse_trig();
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && scl && sda, "R1 reset aborts burst", {busy, scl, sda}, 3'b011);
        pulse_trig();
        wait_idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule